// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a row of boundary scan cells. It sits between the chip pins and the core logic. Each cell carries one pin signal through a data multiplexer. The cell also holds two test bits. A scan flip-flop is clocked on the rising test-clock edge and is linked to its neighbours to form a serial path. An update stage loads on the falling edge and can drive the pin side in place of the live signal. The TAP controller and the instruction decoder drive the strobes that tell the chain when to capture, shift and update. They also drive a test-mode select that chooses which value reaches the outputs.

External test and sample/preload both come from this one structure:

- **External test:** with test mode on, the outputs show the update stage. Pin responses are captured and shifted out while the next stimulus is shifted in. The new stimulus reaches all outputs together, at update.
- **Sample/preload:** with test mode off, the chip runs normally while live values are captured. The update stage can then be loaded before test mode starts.

Top module: `bscan_chain`

## Requirements
- R1: While `rst` is high at a rising edge, every scan bit and the test-mode register clear to 0. Every update bit clears to 0 at the next falling edge. After reset, `ser_out` is 0 and `par_out` equals `par_in`, even if `test_mode` is held high during reset.
- R2: A rising edge with `capture_en` high loads `par_in[i]` into scan cell i. Cell 0 then appears on `ser_out`.
- R3: A rising edge with `shift_en` high and `capture_en` low shifts by one position. Cell i takes cell i+1, and the last cell takes `ser_in`. Cell 0 drives `ser_out`, so after NUM_CELLS shifts, the bit that entered first sits in cell 0.
- R4: When neither `capture_en` nor `shift_en` is high at a rising edge, every scan bit holds its value, whatever `par_in` does.
- R5: The update stage loads from the scan bits only at a falling edge where `update_en` is high. In test mode, `par_out` then shows the new stimulus on all bits at once.
- R6: In test mode, capture and shift never change `par_out`.
- R7: With the registered test mode at 0, `par_out` follows `par_in` combinationally. Capture, shift and update have no effect on it.
- R8: An update made in normal mode (preload) appears on `par_out` at the first rising edge at which `test_mode` is sampled high.
- R9: When `capture_en` and `shift_en` are both high, capture wins.
- R10: `test_mode` is registered on the rising edge. `par_out` switches between `par_in` and the update stage one edge after `test_mode` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; scan on rising edge, update on falling edge |
| rst | input | 1 | Synchronous active-high test-logic reset |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Update strobe, sampled on the falling edge |
| test_mode | input | 1 | Selects the update stage onto the outputs when registered high |
| ser_in | input | 1 | Serial data into the last cell |
| ser_out | output | 1 | Serial data from cell 0 |
| par_in | input | NUM_CELLS | Normal inputs (pin or core side) |
| par_out | output | NUM_CELLS | Normal outputs to the opposite side |

## Verification
- **Scan bit:** a wrong scan bit is invisible at the pins until it is shifted out. It reaches `ser_out` after as many shifts as its distance from cell 0. Its effect on `par_out` waits until the next update in test mode.
- **Update bit or mode register:** a wrong update bit shows on `par_out` as soon as the registered mode is high. A stuck mode register shows within one edge of a `test_mode` change.
- **Checks:** the bench therefore checks both `ser_out` and `par_out` after every clock step. It does this across normal mode, preload, test mode, hold, and simultaneous strobes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } bscan_ctrl_t;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  bscan_ctrl_t ctrl,
  input  logic        test_mode,
  input  logic        pin_in,
  input  logic        scan_in,
  output logic        scan_out,
  output logic        pin_out
);
  logic scan_q;
  logic upd_q;

  // Scan stage: capture has priority over shift, otherwise hold.
  always_ff @(posedge clk) begin
    if (rst)              scan_q <= 1'b0;
    else if (ctrl.capture) scan_q <= pin_in;
    else if (ctrl.shift)   scan_q <= scan_in;
  end

  // Update stage loads on the falling edge so it never races the scan path.
  always_ff @(negedge clk) begin
    if (rst)              upd_q <= 1'b0;
    else if (ctrl.update) upd_q <= scan_q;
  end

  assign scan_out = scan_q;
  assign pin_out  = test_mode ? upd_q : pin_in;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> scan_q == $past(pin_in));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.capture && !ctrl.shift) |=> $stable(scan_q));
  assert_update_only_R5: assert property (@(negedge clk) disable iff (rst)
    (!$past(ctrl.update) && !$past(rst)) |-> $stable(upd_q));
  assert_capture_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && ctrl.shift) |=> scan_q == $past(pin_in));
endmodule

// File: rtl/bscan_mode_reg.sv
module bscan_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic mode_in,
  output logic mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode_in;
  end

  assert_mode_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mode_q);
  assert_mode_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mode_q == $past(mode_in));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture_en,
  input  logic                 shift_en,
  input  logic                 update_en,
  input  logic                 test_mode,
  input  logic                 ser_in,
  output logic                 ser_out,
  input  logic [NUM_CELLS-1:0] par_in,
  output logic [NUM_CELLS-1:0] par_out
);
  localparam int LAST = NUM_CELLS - 1;

  bscan_ctrl_t           ctrl;
  logic                  mode_q;
  logic [NUM_CELLS-1:0]  scan_vec;

  assign ctrl = '{capture: capture_en, shift: shift_en, update: update_en};

  bscan_mode_reg u_mode (
    .clk     (clk),
    .rst     (rst),
    .mode_in (test_mode),
    .mode_q  (mode_q)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic link_in;
    if (i == LAST) begin : g_tail
      assign link_in = ser_in;
    end else begin : g_body
      assign link_in = scan_vec[i+1];
    end
    bscan_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .ctrl      (ctrl),
      .test_mode (mode_q),
      .pin_in    (par_in[i]),
      .scan_in   (link_in),
      .scan_out  (scan_vec[i]),
      .pin_out   (par_out[i])
    );
  end

  assign ser_out = scan_vec[0];

  if (NUM_CELLS > 1) begin : g_shift_chk
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
      (shift_en && !capture_en) |=>
        (scan_vec[LAST-1:0] == $past(scan_vec[LAST:1])) && (scan_vec[LAST] == $past(ser_in)));
  end
endmodule

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, test_mode = 1'b0, ser_in = 1'b0;
  logic [N-1:0] par_in = '0;
  logic         ser_out;
  logic [N-1:0] par_out;

  always #2 clk = ~clk;

  bscan_chain #(.NUM_CELLS(N)) dut_i (
    .clk(clk), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .test_mode(test_mode), .ser_in(ser_in),
    .ser_out(ser_out), .par_in(par_in), .par_out(par_out)
  );

  // Reference state derived from the requirements
  logic [N-1:0] scan_m = '0, upd_m = '0;
  logic         mode_m = 1'b0;

  typedef struct {
    bit           is_vec;
    logic [N-1:0] val;
    string        req;
  } item_t;
  item_t sb_q[$];

  int checks = 0, fails = 0;
  bit done = 0;
  event sample_ev, mon_done;

  // Monitor: pops expected items and compares them with the ports
  initial forever begin
    @(sample_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.is_vec) begin
        if (par_out !== it.val) begin
          fails++;
          $display("FAIL %s par_out actual=%h expected=%h", it.req, par_out, it.val);
        end
      end else if (ser_out !== it.val[0]) begin
        fails++;
        $display("FAIL %s ser_out actual=%b expected=%b", it.req, ser_out, it.val[0]);
      end
    end
    -> mon_done;
  end

  task automatic observe(input string req);
    item_t a, b;
    a.is_vec = 0; a.val = {{(N-1){1'b0}}, scan_m[0]}; a.req = req;
    b.is_vec = 1; b.val = mode_m ? upd_m : par_in;   b.req = req;
    sb_q.push_back(a);
    sb_q.push_back(b);
    -> sample_ev;
    @(mon_done);
  endtask

  // Called at posedge+1; returns at the next posedge+1 after checking
  task automatic step(input bit cap, input bit sh, input bit upd, input bit tm,
                      input bit sin, input string req);
    capture_en = cap; shift_en = sh; update_en = upd; test_mode = tm; ser_in = sin;
    if (upd) upd_m = scan_m;                     // falling edge
    if (cap)     scan_m = par_in;                // rising edge
    else if (sh) scan_m = {sin, scan_m[N-1:1]};
    mode_m = tm;
    @(posedge clk); #1;
    observe(req);
  endtask

  task automatic shift_in(input logic [N-1:0] pat, input bit tm, input string req);
    for (int i = 0; i < N; i++) step(0, 1, 0, tm, pat[i], req);
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1; capture_en = 0; shift_en = 0; update_en = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    scan_m = '0; upd_m = '0; mode_m = 1'b0;
    observe(req);
  endtask

  initial begin
    @(posedge clk); #1;
    par_in = 8'hA5;
    do_reset("R1");
    // sample in normal mode, then shift out
    par_in = 8'h3C;
    step(1, 0, 0, 0, 0, "R2");
    shift_in(8'hA6, 0, "R3");
    // preload while pins stay normal
    step(0, 0, 1, 0, 0, "R7");
    par_in = 8'h0F;
    observe("R7");
    // enter test mode: preloaded value appears
    step(0, 0, 0, 1, 0, "R8");
    par_in = 8'hF0;
    observe("R8");
    // external test: capture and shift leave outputs untouched
    step(1, 0, 0, 1, 0, "R6");
    shift_in(8'h5B, 1, "R6");
    // hold with pins moving
    par_in = 8'h77;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 1, 1, 0, "R5");
    // both strobes: capture wins
    par_in = 8'h81;
    step(1, 1, 0, 1, 1, "R9");
    shift_in(8'hC3, 1, "R3");
    // mode register timing
    step(0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 0, "R10");
    // reset while test_mode held high
    do_reset("R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule